// File: doc/BRIEF.md
# Set/Clear Clock Gate Register Bank

This block holds the on/off state of a group of gated clocks and exposes it on a small word-wide register bus. The enable state has no directly writable register. Software turns gates on by writing ones to a set offset and turns them off by writing ones to a clear offset. It reads the current state back at a separate status offset. Because only the ones in a write take effect, independent agents can flip their own gates without a read-modify-write race.

Each bit position owns one gated clock. A per-bit gating cell derives that clock from the shared input clock. The cell has a latch that is transparent while the clock is low, so an enable change only takes hold between high phases and never cuts a high pulse short. Reset loads the enable state from a parameter.

The address decoder sorts every access into one of four access kinds: STATUS (offset 0x0), SET (offset 0x4), CLEAR (offset 0x8) and OTHER (every other address). The enable register updates only on a write whose kind is SET or CLEAR. The read path returns the state only for a read whose kind is STATUS and returns zero for every other kind.

Top module: `cg_bank`

## Requirements
- R1: While `rst_ni` is low, the enable state is loaded with `INIT_EN`. After release, a status read returns `INIT_EN`, `rdata_o` is zero until the first read, and each gated clock runs exactly when its `INIT_EN` bit is 1.
- R2: A write to offset 0x4 turns on every gate whose bit in `wdata_i` is 1. The change takes effect on the clock edge that samples `wr_en_i`.
- R3: A write to offset 0x8 turns off every gate whose bit in `wdata_i` is 1. The change takes effect on the clock edge that samples `wr_en_i`.
- R4: Bits written as 0 to offset 0x4 or 0x8 leave the corresponding gates unchanged.
- R5: Writes to offset 0x0 or to any address other than 0x4 and 0x8 change no gate.
- R6: A read of offset 0x0 returns the enable state. Bit i holds gate i (1 = on) and the upper bits are zero. `rdata_o` is registered: it updates on the edge that samples `rd_en_i` and holds its value when no read is made.
- R7: A read of offset 0x4, 0x8 or any address other than 0x0 returns zero.
- R8: Gated clock i is low whenever gate i is off and follows `clk_i` when it is on. During the high phase right after the edge that changes the state, the gated clock still shows the old state. The new state shows from the following high phase onward, so no high pulse is truncated.
- R9: Bits of `wdata_i` at positions `NUM_GATES` and above have no effect on any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared input clock, also the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_en_i | input | 1 | Read strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Byte offset from the bank base |
| wdata_i | input | DATA_W | Write data, one bit per gate |
| rdata_o | output | DATA_W | Registered read data |
| gclk_o | output | NUM_GATES | Gated clocks, one per gate |

## Verification
The bench builds the bank with four gates, a 4-bit address and the initial pattern 4'b1010. That makes the full cross of 16 starting states and 16 set/clear masks cheap to sweep, and every mask result can be predicted with plain OR and AND-NOT arithmetic. The 4-bit address space also lets reads and writes reach every offset, including the unmapped ones. Every write in the sweep also samples the gated clocks in the two high phases around the update, so the one-phase delay of the latch is checked on each gate under every transition.

// File: rtl/cg_bank_pkg.sv
package cg_bank_pkg;

    // Access kinds produced by the address decoder
    typedef enum logic [1:0] {
        ACC_STATUS = 2'd0,
        ACC_SET    = 2'd1,
        ACC_CLEAR  = 2'd2,
        ACC_OTHER  = 2'd3
    } acc_e;

    // Byte offsets of the three registers
    localparam int OFF_STATUS = 0;
    localparam int OFF_SET    = 4;
    localparam int OFF_CLEAR  = 8;

endpackage

// File: rtl/cg_addr_decode.sv
module cg_addr_decode
    import cg_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_e              kind_o
);

    always_comb begin
        if (addr_i == ADDR_W'(OFF_STATUS)) begin
            kind_o = ACC_STATUS;
        end else if (addr_i == ADDR_W'(OFF_SET)) begin
            kind_o = ACC_SET;
        end else if (addr_i == ADDR_W'(OFF_CLEAR)) begin
            kind_o = ACC_CLEAR;
        end else begin
            kind_o = ACC_OTHER;
        end
    end

endmodule

// File: rtl/cg_enable_reg.sv
module cg_enable_reg
    import cg_bank_pkg::*;
#(
    parameter int                 NUM_GATES = 8,
    parameter logic [NUM_GATES-1:0] INIT_EN = '0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  acc_e                 kind_i,
    input  logic [NUM_GATES-1:0] mask_i,
    output logic [NUM_GATES-1:0] en_o
);

    logic [NUM_GATES-1:0] set_m;
    logic [NUM_GATES-1:0] clr_m;
    logic [NUM_GATES-1:0] en_d;
    logic [NUM_GATES-1:0] en_q;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (wr_en_i) begin
            unique case (kind_i)
                ACC_SET:    set_m = mask_i;
                ACC_CLEAR:  clr_m = mask_i;
                ACC_STATUS,
                ACC_OTHER:  ;
                default:    ;
            endcase
        end
        // clear applied last: a bit both set and cleared ends off
        en_d = (en_q | set_m) & ~clr_m;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= INIT_EN;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_l;

    // enable passes only while the clock is low, held during the high phase
    always_latch begin
        if (!clk_i) begin
            en_l = en_i;
        end
    end

    assign gclk_o = clk_i & en_l;

endmodule

// File: rtl/cg_bank.sv
module cg_bank
    import cg_bank_pkg::*;
#(
    parameter int                   NUM_GATES = 8,
    parameter int                   ADDR_W    = 4,
    parameter int                   DATA_W    = 32,
    parameter logic [NUM_GATES-1:0] INIT_EN   = '0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NUM_GATES-1:0] gclk_o
);

    localparam int MASK_W = (NUM_GATES < DATA_W) ? NUM_GATES : DATA_W;

    acc_e                 kind;
    logic [NUM_GATES-1:0] mask;
    logic [NUM_GATES-1:0] en_q;
    logic [DATA_W-1:0]    rdata_q;

    always_comb begin
        mask         = '0;
        mask[MASK_W-1:0] = wdata_i[MASK_W-1:0];
    end

    cg_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr_i (addr_i),
        .kind_o (kind)
    );

    cg_enable_reg #(
        .NUM_GATES (NUM_GATES),
        .INIT_EN   (INIT_EN)
    ) u_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .kind_i  (kind),
        .mask_i  (mask),
        .en_o    (en_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            unique case (kind)
                ACC_STATUS: rdata_q <= DATA_W'(en_q);
                ACC_SET,
                ACC_CLEAR,
                ACC_OTHER:  rdata_q <= '0;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign rdata_o = rdata_q;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_cell
        cg_gate_cell u_cell (
            .clk_i  (clk_i),
            .en_i   (en_q[g]),
            .gclk_o (gclk_o[g])
        );
    end

endmodule

// File: rtl/cg_bank_chk.sv
module cg_bank_chk #(
    parameter int NUM_GATES = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic                 rd_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [DATA_W-1:0]    wdata_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic [NUM_GATES-1:0] en_q
);

    localparam int MW = (NUM_GATES < DATA_W) ? NUM_GATES : DATA_W;

    logic is_set, is_clr, is_stat;
    logic [NUM_GATES-1:0] wm;

    always_comb begin
        is_set  = (addr_i == ADDR_W'(4));
        is_clr  = (addr_i == ADDR_W'(8));
        is_stat = (addr_i == ADDR_W'(0));
        wm      = '0;
        wm[MW-1:0] = wdata_i[MW-1:0];
    end

    AST_SET_TURNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && is_set |=> (en_q & $past(wm)) == $past(wm)); // R2

    AST_CLR_TURNS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && is_clr |=> (en_q & $past(wm)) == '0); // R3

    AST_ZERO_BITS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && (is_set || is_clr) |=> (en_q & ~$past(wm)) == ($past(en_q) & ~$past(wm))); // R4

    AST_OTHER_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (is_set || is_clr)) |=> $stable(en_q)); // R5

    AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && is_stat |=> rdata_o == DATA_W'($past(en_q))); // R6

    AST_IDLE_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o)); // R6

    AST_NONSTATUS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && !is_stat |=> rdata_o == '0); // R7

endmodule

bind cg_bank cg_bank_chk #(
    .NUM_GATES (NUM_GATES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_q    (en_q)
);

// File: tb/cg_bank_tb.sv
module cg_bank_tb;

    localparam int       NG   = 4;
    localparam int       AW   = 4;
    localparam int       DW   = 32;
    localparam logic [NG-1:0] INIT = 4'b1010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NG-1:0] gclk;

    int vectors = 0;
    int errors  = 0;
    logic [NG-1:0] exp_st;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cg_bank #(
        .NUM_GATES (NG),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .INIT_EN   (INIT)
    ) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .gclk_o  (gclk)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write, checking the gated clocks in the two high phases around the update
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [NG-1:0] old_st;
        logic [NG-1:0] new_st;
        old_st = exp_st;
        new_st = old_st;
        if (a == AW'(4)) new_st = old_st | d[NG-1:0];
        if (a == AW'(8)) new_st = old_st & ~d[NG-1:0];
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        chk("R8 old phase", DW'(gclk), DW'(old_st));
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 new phase", DW'(gclk), DW'(new_st));
        exp_st = new_st;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        exp_st = INIT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata reset", rdata, '0);
        @(posedge clk);
        #1;
        chk("R1 gates reset", DW'(gclk), DW'(INIT));
        do_read(4'h0, DW'(INIT), "R1 status after reset");

        // R7: non-status offsets read zero
        for (int a = 1; a < 16; a++) begin
            do_read(AW'(a), '0, "R7 non-status read");
        end

        // R6: rdata holds when no read is made
        do_read(4'h0, DW'(INIT), "R6 status read");
        @(negedge clk);
        @(negedge clk);
        chk("R6 rdata hold", rdata, DW'(INIT));

        // R5: writes to status and unmapped offsets change nothing
        for (int a = 0; a < 16; a++) begin
            if (a != 4 && a != 8) begin
                do_write(AW'(a), '1);
                do_write(AW'(a), '0);
                do_read(4'h0, DW'(exp_st), "R5 ignored write");
            end
        end
        chk("R5 state kept", DW'(exp_st), DW'(INIT));

        // R9: bits above the gate count have no effect
        do_write(4'h4, 32'hFFFF_FFF0);
        do_read(4'h0, DW'(INIT), "R9 upper set bits");
        do_write(4'h8, 32'hFFFF_FFF0);
        do_read(4'h0, DW'(INIT), "R9 upper clear bits");

        // R2, R3, R4: full sweep of start states and masks
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                do_write(4'h8, 32'hF);
                do_write(4'h4, DW'(s));
                do_read(4'h0, DW'(s), "R2 set from zero");
                do_write(4'h4, DW'(m));
                do_read(4'h0, DW'(s | m), "R2 R4 set mask");
                do_write(4'h8, DW'(m));
                do_read(4'h0, DW'((s | m) & ~m), "R3 R4 clear mask");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule